// File: doc/BRIEF.md
# Serial Command and Display-RAM Write Decoder

This block takes 8-bit words from a three-wire synchronous serial link: an active-low select, a serial clock and a data line. All three are brought into the system clock domain, and rising edges of the serial clock are detected there. Each word arrives least significant bit first.

The first word after select goes low decides what the transaction does. It can load the display configuration register, load the starting character position, or set a display-RAM write pointer. When it sets the pointer, every later word in the same transaction goes out on a one-cycle RAM write port, and the pointer then steps by one. When it loads a register, the words that follow are discarded. Raising select ends the transaction and re-arms first-word classification.

The configuration fields are held on plain outputs for the scan logic that follows. The RAM array, the scanning and the output drive lie outside this block.

Top module: `vfd_serial_decoder`

States of the controller:

- `ST_FIRST` waits for the classifying word.
- `ST_DATA` stores words to RAM.
- `ST_SKIP` discards words.

Transitions:

- `ST_FIRST` to `ST_DATA` on a pointer word.
- `ST_FIRST` to `ST_SKIP` on either register word.
- `ST_DATA` or `ST_SKIP` back to `ST_FIRST` when select is high and no word is pending.

## Requirements
- R1: A word is eight data samples, taken on serial-clock rising edges while select is low, with the first sample placed in bit 0. Raising select drops any partly received word and makes the next word a first word again.
- R2: A first word with bit 7 = 1 loads the configuration: duty code from bits 6..4, display enable from bit 3, shift-digit code from bits 2..0.
- R3: A first word with bits 7..6 = 01 loads the character position from bits 3..0. Bits 5..4 have no effect.
- R4: A character position code of 15 is stored as 14. The character output never exceeds 14.
- R5: A first word with bits 7..6 = 00 sets the write pointer from bits 4..0, and bit 5 has no effect. Each later word in the transaction gives a single-cycle write strobe carrying that word and the current pointer, and the pointer then increments.
- R6: The pointer is 5 bits and wraps from 31 to 0. Words landing on 30 or 31 produce no strobe, but the pointer still advances past them.
- R7: After a register-loading first word, later words in the same transaction produce no strobe and change no configuration output.
- R8: After reset the outputs are: duty code 0, display off, shift code 7, character position 1, and no write strobe.
- R9: While select stays high, no configuration output changes and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, sampled on its rising edge |
| sdi_i | input | 1 | Serial data |
| duty_o | output | 3 | Duty code |
| disp_en_o | output | 1 | Display enable |
| shift_code_o | output | 3 | Shift-digit code |
| char_pos_o | output | 4 | Starting character position (0..14) |
| ram_we_o | output | 1 | RAM write strobe, one cycle |
| ram_addr_o | output | 5 | RAM write address |
| ram_data_o | output | 8 | RAM write data |

## Verification
The bench sends a run of data words from pointer 28, so that the pointer crosses 30, 31 and 0. A design that wrapped early, wrote the two dead locations or stalled the pointer would show missing or extra strobes, or wrong addresses.

It sends data words after each kind of register word. A design that kept storing or re-decoding them would raise strobes or corrupt the configuration.

It aborts a transaction after three bits and then sends a fresh register word. A bit counter that survived the abort would misalign that word and load wrong fields.

It also sends a character code of 15 and sets the don't-care bits in both the pointer and character words. A missing clamp or a decode that leaks those bits would show up on the outputs.

// File: rtl/vfdsd_pkg.sv
package vfdsd_pkg;

    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_DATA  = 2'd1,
        ST_SKIP  = 2'd2
    } dec_state_t;

    typedef enum logic [1:0] {
        CL_PTR  = 2'd0,
        CL_POS  = 2'd1,
        CL_CFG  = 2'd2
    } word_class_t;

    typedef struct packed {
        logic [2:0] duty;
        logic       en;
        logic [2:0] shift;
        logic [3:0] pos;
    } cfg_t;

    // prefix decode: top bit set selects configuration, else bit 6 selects position
    function automatic word_class_t classify(input logic [7:0] w);
        if (w[7])      return CL_CFG;
        else if (w[6]) return CL_POS;
        else           return CL_PTR;
    endfunction

endpackage

// File: rtl/vfdsd_sync.sv
module vfdsd_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/vfdsd_shifter.sv
module vfdsd_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic              sclk_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] sreg;
    logic              rise;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            bit_cnt    <= '0;
            sreg       <= '0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
        end else begin
            sclk_d     <= sclk_s;
            word_vld_o <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                sreg <= {sdi_s, sreg[WORD_W-1:1]};
                if (bit_cnt == LAST) begin
                    bit_cnt    <= '0;
                    word_vld_o <= 1'b1;
                    word_o     <= {sdi_s, sreg[WORD_W-1:1]};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vfdsd_ctrl.sv
module vfdsd_ctrl
    import vfdsd_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int RAM_DEPTH = 30,
    parameter int POS_MAX   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              word_vld,
    input  logic [7:0]        word,
    output cfg_t              cfg_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o
);
    localparam logic [ADDR_W-1:0] DEPTH_L   = ADDR_W'(RAM_DEPTH);
    localparam logic [3:0]        POS_MAX_L = 4'(POS_MAX);
    localparam cfg_t CFG_RST = '{duty: 3'd0, en: 1'b0, shift: 3'd7, pos: 4'd1};

    dec_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    word_class_t       cls;

    assign cls = classify(word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIRST: begin
                if (word_vld) begin
                    if (cls == CL_PTR) state_d = ST_DATA;
                    else               state_d = ST_SKIP;
                end
            end
            ST_DATA, ST_SKIP: begin
                if (!word_vld && cs_n_s) state_d = ST_FIRST;
            end
            default: state_d = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o  <= CFG_RST;
            ptr_q  <= '0;
            we_o   <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            we_o <= 1'b0;
            if (word_vld) begin
                unique case (state_q)
                    ST_FIRST: begin
                        unique case (cls)
                            CL_CFG: begin
                                cfg_o.duty  <= word[6:4];
                                cfg_o.en    <= word[3];
                                cfg_o.shift <= word[2:0];
                            end
                            CL_POS: cfg_o.pos <= (word[3:0] > POS_MAX_L) ? POS_MAX_L : word[3:0];
                            CL_PTR: ptr_q <= word[ADDR_W-1:0];
                            default: ;
                        endcase
                    end
                    ST_DATA: begin
                        if (ptr_q < DEPTH_L) begin
                            we_o   <= 1'b1;
                            addr_o <= ptr_q;
                            data_o <= word;
                        end
                        ptr_q <= ptr_q + 1'b1;
                    end
                    ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vfd_serial_decoder.sv
module vfd_serial_decoder
    import vfdsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5,
    parameter int RAM_DEPTH   = 30,
    parameter int POS_MAX     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [2:0]        duty_o,
    output logic              disp_en_o,
    output logic [2:0]        shift_code_o,
    output logic [3:0]        char_pos_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [7:0]        ram_data_o
);
    logic [2:0] pins_s;
    logic       word_vld;
    logic [7:0] word;
    cfg_t       cfg;

    vfdsd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_n_i, sclk_i, sdi_i}),
        .q_o(pins_s)
    );

    vfdsd_shifter #(.WORD_W(8)) shf_i (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
        .word_vld_o(word_vld), .word_o(word)
    );

    vfdsd_ctrl #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .POS_MAX(POS_MAX)) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(pins_s[2]), .word_vld(word_vld), .word(word),
        .cfg_o(cfg), .we_o(ram_we_o), .addr_o(ram_addr_o), .data_o(ram_data_o)
    );

    assign duty_o       = cfg.duty;
    assign disp_en_o    = cfg.en;
    assign shift_code_o = cfg.shift;
    assign char_pos_o   = cfg.pos;
endmodule

// File: rtl/vfdsd_checker.sv
module vfdsd_checker #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5,
    parameter int RAM_DEPTH   = 30,
    parameter int POS_MAX     = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic [2:0]        duty_o,
    input logic              disp_en_o,
    input logic [2:0]        shift_code_o,
    input logic [3:0]        char_pos_o,
    input logic              ram_we_o,
    input logic [ADDR_W-1:0] ram_addr_o
);
    localparam int QUIET = SYNC_STAGES + 4;
    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_cnt <= '0;
        else if (!cs_n_i)        hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_WE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o < ADDR_W'(RAM_DEPTH)));              // R6
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> !ram_we_o);                                       // R5
    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        char_pos_o <= 4'(POS_MAX));                                    // R4
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_cnt) >= QUIET) |-> ($stable({duty_o, disp_en_o, shift_code_o, char_pos_o}) && !ram_we_o)); // R9
    AST_RESET_VAL: assert property (@(posedge clk)
        $rose(rst_n) |-> (duty_o == 3'd0 && !disp_en_o && shift_code_o == 3'd7 && char_pos_o == 4'd1 && !ram_we_o)); // R8
endmodule

bind vfd_serial_decoder vfdsd_checker #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .POS_MAX(POS_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i),
    .duty_o(duty_o), .disp_en_o(disp_en_o), .shift_code_o(shift_code_o),
    .char_pos_o(char_pos_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o)
);

// File: tb/vfd_serial_decoder_tb.sv
module vfd_serial_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [2:0] duty, shift;
    logic       en, we;
    logic [3:0] pos;
    logic [4:0] waddr;
    logic [7:0] wdata;

    int n_run = 0, n_fail = 0;
    int wr_cnt = 0;
    logic [4:0] wr_a [16];
    logic [7:0] wr_d [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    vfd_serial_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .duty_o(duty), .disp_en_o(en), .shift_code_o(shift), .char_pos_o(pos),
        .ram_we_o(we), .ram_addr_o(waddr), .ram_data_o(wdata)
    );

    always @(negedge clk) begin
        if (rst_n && we && wr_cnt < 16) begin
            wr_a[wr_cnt] = waddr;
            wr_d[wr_cnt] = wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        sdi = b;  wait_clk(4);
        sclk = 1; wait_clk(4);
        sclk = 0;
    endtask

    task automatic send_word(input logic [7:0] w);
        for (int i = 0; i < 8; i++) send_bit(w[i]);
    endtask

    task automatic begin_tx();
        cs_n = 0; wait_clk(4);
    endtask

    task automatic end_tx();
        wait_clk(10); cs_n = 1; wait_clk(10);
    endtask

    task automatic chk_cfg(input string tag, input int d, input int e, input int s, input int p);
        chk(duty == 3'(d), tag, duty, d);
        chk(en == 1'(e), tag, en, e);
        chk(shift == 3'(s), tag, shift, s);
        chk(pos == 4'(p), tag, pos, p);
    endtask

    task automatic t_reset();
        chk_cfg("R8 reset cfg", 0, 0, 7, 1);
        chk(we == 0, "R8 no strobe", we, 0);
    endtask

    task automatic t_cfg();
        begin_tx(); send_word(8'hB5); end_tx();
        chk_cfg("R2 cfg B5", 3, 0, 5, 1);
        begin_tx(); send_word(8'hFA); end_tx();
        chk_cfg("R2 cfg FA", 7, 1, 2, 1);
    endtask

    task automatic t_pos();
        begin_tx(); send_word(8'h75); end_tx();
        chk(pos == 4'd5, "R3 pos dontcare bits", pos, 5);
        begin_tx(); send_word(8'h4F); end_tx();
        chk(pos == 4'd14, "R4 clamp 15", pos, 14);
        begin_tx(); send_word(8'h43); end_tx();
        begin_tx(); send_word(8'h4E); end_tx();
        chk(pos == 4'd14, "R4 code 14 kept", pos, 14);
        chk_cfg("R9 cfg held", 7, 1, 2, 14);
    endtask

    task automatic t_write();
        wr_cnt = 0;
        begin_tx(); send_word(8'h23); send_word(8'hA1); send_word(8'hB2); send_word(8'hC3); end_tx();
        chk(wr_cnt == 3, "R5 write count", wr_cnt, 3);
        for (int i = 0; i < 3; i++) begin
            chk(wr_a[i] == 5'(3 + i), "R5 address", wr_a[i], 3 + i);
            chk(wr_d[i] == 8'(8'hA1 + 8'h11 * i), "R5 data", wr_d[i], 8'hA1 + 8'h11 * i);
        end
    endtask

    task automatic t_wrap();
        wr_cnt = 0;
        begin_tx(); send_word(8'h1C);
        for (int i = 0; i < 5; i++) send_word(8'(8'h50 + i));
        end_tx();
        chk(wr_cnt == 3, "R6 writes skip 30/31", wr_cnt, 3);
        chk(wr_a[0] == 5'd28 && wr_d[0] == 8'h50, "R6 first", wr_a[0], 28);
        chk(wr_a[1] == 5'd29 && wr_d[1] == 8'h51, "R6 second", wr_a[1], 29);
        chk(wr_a[2] == 5'd0 && wr_d[2] == 8'h54, "R6 wrapped", wr_a[2], 0);
    endtask

    task automatic t_skip();
        wr_cnt = 0;
        begin_tx(); send_word(8'h80); send_word(8'hFF); send_word(8'h4A); end_tx();
        chk(wr_cnt == 0, "R7 no strobe after cfg", wr_cnt, 0);
        chk_cfg("R7 cfg untouched by later", 0, 0, 0, 14);
        begin_tx(); send_word(8'h42); send_word(8'h00); send_word(8'hFF); end_tx();
        chk(wr_cnt == 0, "R7 no strobe after pos", wr_cnt, 0);
        chk_cfg("R7 pos untouched by later", 0, 0, 0, 2);
    endtask

    task automatic t_abort();
        begin_tx(); send_bit(1); send_bit(1); send_bit(0); end_tx();
        chk_cfg("R1 partial dropped", 0, 0, 0, 2);
        begin_tx(); send_word(8'hC9); end_tx();
        chk_cfg("R1 realigned", 4, 1, 1, 2);
    endtask

    initial begin
        wait_clk(3); rst_n = 1; wait_clk(2);
        t_reset();
        t_cfg();
        t_pos();
        t_write();
        t_wrap();
        t_skip();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule